// File: doc/BRIEF.md
# Audio Serial Output Formatter

This block turns a stream of 24-bit left/right sample pairs into a three-wire serial audio output: a bit clock, a word clock and one serial data line. A 3-bit mode input selects one of eight framings. Four are right-justified at 16, 18, 20 or 24 bits. Two are 24-bit left-justified, one with the block timing the link and one with the link timed from outside. The remaining two are 24-bit I2S, again one of each. When the block times the link, it builds the bit clock from a single-cycle enable, with 64 bit clocks to each word-clock period. When the link is timed from outside, it synchronises the external bit and word clocks and follows their edges.

On the same bit clocks the block also captures an auxiliary serial input. After each full frame it presents that input as a left/right pair of 24-bit words. A receiver upstream reports two error conditions: a data error (parity, biphase or frame length) and loss of lock. On a data error the block repeats the last good pair. On loss of lock it sends silence.

Top module: `audio_serial_fmt`

## Requirements
- R1: In modes 0 to 5 (`mode[2:1] != 2'b11`), `bclkOut` toggles on every clock cycle in which `bitTick` is high. There are exactly 64 bit-clock periods from one left-slot start to the next, with 32 in each channel slot.
- R2: The word clock changes only on a falling bit-clock edge. It is high during the left slot in modes 0, 1, 2, 3, 4 and 6, and low during the left slot in modes 5 and 7.
- R3: `sdOut` changes only on a falling bit-clock edge. Each sample is sent MSB first, in two's complement.
- R4: Modes 0, 1, 2 and 3 carry W = 16, 18, 20 and 24 bits. Slot positions 32−W to 31 hold sample bits 23 down to 24−W. Earlier positions are zero, and the low sample bits beyond W are dropped.
- R5: In modes 4 and 6, slot positions 0 to 23 hold sample bits 23 to 0, and every later position is zero.
- R6: In modes 5 and 7, position 0 (the word-clock edge) is zero, positions 1 to 24 hold sample bits 23 to 0, and every later position is zero.
- R7: `leftIn`/`rightIn` are sampled only at the falling edge that opens a left slot. Both channels of a frame therefore come from the same pair, even if the inputs change mid-frame.
- R8: If `errHold` is high when a left slot opens, the previous pair is sent again.
- R9: If `unlock` is high when a left slot opens, an all-zero pair is sent, whatever the state of `errHold`. Normal data resumes at the first left slot after `unlock` falls.
- R10: `auxIn` is sampled on rising bit-clock edges. It is taken as 24-bit left-justified in modes 0, 1, 2, 3, 4 and 6, and as I2S in modes 5 and 7. The captured pair appears on `auxLeft`/`auxRight`, with a one-cycle `auxValid`, at the start of the next left slot.
- R11: In modes 6 and 7, `bclkIn`/`lrclkIn` pass through a two-stage synchroniser. Each word-clock edge restarts the slot position. Slots longer than 32 bits, up to 64 per channel, are padded with zeros. `bclkOut` and `lrclkOut` stay low.
- R12: During reset, `bclkOut`, `lrclkOut`, `sdOut`, `auxValid`, `auxLeft` and `auxRight` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Format select (0–7) |
| bitTick | input | 1 | Bit-clock half-period enable, used when the block times the link |
| leftIn | input | 24 | Left sample |
| rightIn | input | 24 | Right sample |
| errHold | input | 1 | Receiver data error: repeat the last pair |
| unlock | input | 1 | Receiver loss of lock: send zeros |
| bclkIn | input | 1 | External bit clock (modes 6, 7) |
| lrclkIn | input | 1 | External word clock (modes 6, 7) |
| auxIn | input | 1 | Auxiliary serial data input |
| bclkOut | output | 1 | Generated bit clock |
| lrclkOut | output | 1 | Generated word clock |
| sdOut | output | 1 | Serial data output |
| auxLeft | output | 24 | Captured auxiliary left word |
| auxRight | output | 24 | Captured auxiliary right word |
| auxValid | output | 1 | Pulse when a new auxiliary pair is presented |

## Verification
When the block times the link, `sdOut`, `lrclkOut` and the falling `bclkOut` all update on the same clock edge that consumes `bitTick`. The bench records each bit at the falling clock edge that follows. In modes 6 and 7 the synchroniser and edge detector add three clock cycles after an external bit-clock edge. The bench therefore holds each external half-period for four cycles and reads `sdOut` at the end of the high phase. The auxiliary pair and its strobe become visible on the edge that opens the next left slot, so the bench reads them at the first falling clock edge inside that slot.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  localparam int POS_W = 6;

  typedef struct packed {
    logic             fall;
    logic             rise;
    logic             frameStart;
    logic             isRight;
    logic [POS_W-1:0] pos;
  } fmtStrobe_t;

  function automatic logic modeIsMaster(input logic [2:0] m);
    return m[2:1] != 2'b11;
  endfunction

  function automatic logic modeIsI2s(input logic [2:0] m);
    return m[2] & m[0];
  endfunction

endpackage

// File: rtl/fmt_ctrl.sv
module fmt_ctrl import fmt_pkg::*; #(
  parameter int SLOT_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] mode,
  input  logic       bitTick,
  input  logic       bclkIn,
  input  logic       lrclkIn,
  output logic       bclkOut,
  output logic       lrclkOut,
  output fmtStrobe_t stb
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_BITS - 1);
  localparam logic [POS_W-1:0] MAX_POS  = '1;

  logic isMaster, isI2s;
  logic [1:0] bSync, lSync;
  logic bPrev, lrPrev;
  logic fall, rise, lrEdge;
  logic [POS_W-1:0] posReg, posNext;
  logic rightReg, rightNext;

  assign isMaster = modeIsMaster(mode);
  assign isI2s    = modeIsI2s(mode);

  always_comb begin
    fall      = isMaster ? (bitTick & bclkOut)  : (bPrev & ~bSync[1]);
    rise      = isMaster ? (bitTick & ~bclkOut) : (~bPrev & bSync[1]);
    lrEdge    = lSync[1] ^ lrPrev;
    posNext   = posReg;
    rightNext = rightReg;
    if (isMaster) begin
      if (posReg >= LAST_POS) begin
        posNext   = '0;
        rightNext = ~rightReg;
      end else begin
        posNext = posReg + 1'b1;
      end
    end else if (lrEdge) begin
      posNext   = '0;
      rightNext = lSync[1] ^ ~isI2s;
    end else if (posReg != MAX_POS) begin
      posNext = posReg + 1'b1;
    end
  end

  assign stb.fall       = fall;
  assign stb.rise       = rise;
  assign stb.frameStart = fall & ~rightNext & (posNext == '0);
  assign stb.isRight    = fall ? rightNext : rightReg;
  assign stb.pos        = fall ? posNext : posReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bSync    <= '0;
      lSync    <= '0;
      bPrev    <= 1'b0;
      lrPrev   <= 1'b0;
      posReg   <= LAST_POS;
      rightReg <= 1'b1;
      bclkOut  <= 1'b0;
      lrclkOut <= 1'b0;
    end else begin
      bSync <= {bSync[0], bclkIn};
      lSync <= {lSync[0], lrclkIn};
      bPrev <= bSync[1];
      if (!isMaster && fall) lrPrev <= lSync[1];
      if (fall) begin
        posReg   <= posNext;
        rightReg <= rightNext;
      end
      if (isMaster) begin
        if (bitTick) bclkOut <= ~bclkOut;
        if (fall)    lrclkOut <= rightNext ^ ~isI2s;
      end else begin
        bclkOut  <= 1'b0;
        lrclkOut <= 1'b0;
      end
    end
  end

  // R1: a generated slot never runs past its last position
  assert_master_slot_R1: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && fall) |-> (stb.pos <= LAST_POS));

  // R2: generated word clock moves only with a falling bit clock
  assert_lr_on_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !fall) |=> $stable(lrclkOut));

  // R11: clock outputs idle while timed from outside
  assert_slave_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |=> (!bclkOut && !lrclkOut));

  // R1: never a rise and a fall in one cycle
  assert_one_edge_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.fall, stb.rise}));

endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath import fmt_pkg::*; #(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          mode,
  input  fmtStrobe_t          stb,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                errHold,
  input  logic                unlock,
  input  logic                auxIn,
  output logic                sdOut,
  output logic [SAMPLE_W-1:0] auxLeft,
  output logic [SAMPLE_W-1:0] auxRight,
  output logic                auxValid
);

  localparam int IDX_W = $clog2(SAMPLE_W);

  logic isMaster, isI2s;
  logic [SAMPLE_W-1:0] pairL, pairR, nextL, nextR, word;
  logic [SAMPLE_W-1:0] auxBufL, auxBufR;
  logic [POS_W-1:0] fieldStart, fieldWidth, off, auxStart, auxOff;
  logic [IDX_W-1:0] bitIdx, auxIdx;
  logic inField, inAux, bitVal, auxBit;
  logic [1:0] auxSync;

  assign isMaster = modeIsMaster(mode);
  assign isI2s    = modeIsI2s(mode);

  always_comb begin
    case (mode)
      3'd0:    begin fieldWidth = POS_W'(SAMPLE_W - 8); fieldStart = POS_W'(SLOT_BITS - SAMPLE_W + 8); end
      3'd1:    begin fieldWidth = POS_W'(SAMPLE_W - 6); fieldStart = POS_W'(SLOT_BITS - SAMPLE_W + 6); end
      3'd2:    begin fieldWidth = POS_W'(SAMPLE_W - 4); fieldStart = POS_W'(SLOT_BITS - SAMPLE_W + 4); end
      3'd3:    begin fieldWidth = POS_W'(SAMPLE_W);     fieldStart = POS_W'(SLOT_BITS - SAMPLE_W);     end
      3'd5,
      3'd7:    begin fieldWidth = POS_W'(SAMPLE_W);     fieldStart = POS_W'(1);                        end
      default: begin fieldWidth = POS_W'(SAMPLE_W);     fieldStart = '0;                               end
    endcase
  end

  always_comb begin
    if (unlock)       begin nextL = '0;    nextR = '0;      end
    else if (errHold) begin nextL = pairL; nextR = pairR;   end
    else              begin nextL = leftIn; nextR = rightIn; end
  end

  assign word    = stb.frameStart ? nextL : (stb.isRight ? pairR : pairL);
  assign off     = stb.pos - fieldStart;
  assign inField = (stb.pos >= fieldStart) && (off < fieldWidth);
  assign bitIdx  = IDX_W'(SAMPLE_W - 1) - IDX_W'(off);
  assign bitVal  = inField ? word[bitIdx] : 1'b0;

  assign auxStart = isI2s ? POS_W'(1) : '0;
  assign auxOff   = stb.pos - auxStart;
  assign inAux    = (stb.pos >= auxStart) && (auxOff < POS_W'(SAMPLE_W));
  assign auxIdx   = IDX_W'(SAMPLE_W - 1) - IDX_W'(auxOff);
  assign auxBit   = isMaster ? auxIn : auxSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairL    <= '0;
      pairR    <= '0;
      sdOut    <= 1'b0;
      auxSync  <= '0;
      auxBufL  <= '0;
      auxBufR  <= '0;
      auxLeft  <= '0;
      auxRight <= '0;
      auxValid <= 1'b0;
    end else begin
      auxSync <= {auxSync[0], auxIn};
      if (stb.frameStart) begin
        pairL    <= nextL;
        pairR    <= nextR;
        auxLeft  <= auxBufL;
        auxRight <= auxBufR;
      end
      auxValid <= stb.frameStart;
      if (stb.fall) sdOut <= bitVal;
      if (stb.rise && inAux) begin
        if (stb.isRight) auxBufR[auxIdx] <= auxBit;
        else             auxBufL[auxIdx] <= auxBit;
      end
    end
  end

  // R3: data line moves only with a falling bit clock
  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.fall |=> $stable(sdOut));

  // R8: a held error keeps the stored pair
  assert_hold_on_error_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameStart && errHold && !unlock) |=> ($stable(pairL) && $stable(pairR)));

  // R9: lock loss clears the pair
  assert_zero_on_unlock_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameStart && unlock) |=> (pairL == '0 && pairR == '0));

  // R10: auxiliary strobe lasts one cycle
  assert_aux_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    auxValid |=> !auxValid);

endmodule

// File: rtl/audio_serial_fmt.sv
module audio_serial_fmt import fmt_pkg::*; #(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          mode,
  input  logic                bitTick,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic                errHold,
  input  logic                unlock,
  input  logic                bclkIn,
  input  logic                lrclkIn,
  input  logic                auxIn,
  output logic                bclkOut,
  output logic                lrclkOut,
  output logic                sdOut,
  output logic [SAMPLE_W-1:0] auxLeft,
  output logic [SAMPLE_W-1:0] auxRight,
  output logic                auxValid
);

  fmtStrobe_t stb;

  fmt_ctrl #(.SLOT_BITS(SLOT_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .bitTick(bitTick),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .stb(stb)
  );

  fmt_datapath #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_data (
    .clk(clk), .rstN(rstN), .mode(mode), .stb(stb),
    .leftIn(leftIn), .rightIn(rightIn), .errHold(errHold), .unlock(unlock),
    .auxIn(auxIn), .sdOut(sdOut), .auxLeft(auxLeft), .auxRight(auxRight),
    .auxValid(auxValid)
  );

endmodule

// File: tb/audio_serial_fmt_tb.sv
module audio_serial_fmt_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, bitTick, errHold, unlock, bclkIn, lrclkIn, auxIn;
  logic [2:0] mode;
  logic [23:0] leftIn, rightIn, auxLeft, auxRight;
  logic bclkOut, lrclkOut, sdOut, auxValid;

  audio_serial_fmt u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .bitTick(bitTick),
    .leftIn(leftIn), .rightIn(rightIn), .errHold(errHold), .unlock(unlock),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn), .auxIn(auxIn),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdOut(sdOut),
    .auxLeft(auxLeft), .auxRight(auxRight), .auxValid(auxValid)
  );

  typedef struct packed {
    logic [2:0]  m;
    logic [23:0] l;
    logic [23:0] r;
    logic [23:0] al;
    logic [23:0] ar;
    logic [6:0]  slot;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 24'hC3A501, 24'h7E1234, 24'h9ABCDE, 24'h13579B, 7'd32},
    '{3'd1, 24'h80F00F, 24'h0FF0F1, 24'h2468AC, 24'hECA864, 7'd32},
    '{3'd2, 24'hFFFFFF, 24'h000001, 24'hA0A0A0, 24'h0B0B0B, 7'd32},
    '{3'd3, 24'h800001, 24'h7FFFFE, 24'h111111, 24'hEEEEEE, 7'd32},
    '{3'd4, 24'h5A5A5A, 24'hA5A5A5, 24'hC0FFEE, 24'hBADCAF, 7'd32},
    '{3'd5, 24'hD00D11, 24'h2BCD34, 24'h876543, 24'h345678, 7'd32},
    '{3'd6, 24'h6B1C2D, 24'h94E3D2, 24'h55AA55, 24'hAA55AA, 7'd32},
    '{3'd7, 24'hE1F2A3, 24'h1E0D5C, 24'h0F1E2D, 24'hF0E1D2, 7'd40}
  };

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] capL, capR;
  logic [23:0] auxWL, auxWR;
  logic [2:0] curMode;
  logic curRight, prevB, lastLr, prevSd;
  int idx, frames, falls, fallsLast, sdViol;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic isI2sMode(input logic [2:0] m);
    return (m == 3'd5) || (m == 3'd7);
  endfunction

  function automatic logic expBit(input logic [2:0] m, input logic [23:0] s, input int i);
    int st, w;
    case (m)
      3'd0: begin st = 16; w = 16; end
      3'd1: begin st = 14; w = 18; end
      3'd2: begin st = 12; w = 20; end
      3'd3: begin st = 8;  w = 24; end
      3'd5, 3'd7: begin st = 1; w = 24; end
      default: begin st = 0; w = 24; end
    endcase
    if (i >= st && (i - st) < w) return s[23 - (i - st)];
    return 1'b0;
  endfunction

  function automatic logic [63:0] expVec(input logic [2:0] m, input logic [23:0] s, input int slot);
    logic [63:0] v = '0;
    for (int i = 0; i < slot; i++) v[63 - i] = expBit(m, s, i);
    return v;
  endfunction

  function automatic logic auxBitFor(input logic [2:0] m, input logic [23:0] a, input int i);
    int st = isI2sMode(m) ? 1 : 0;
    if (i >= st && (i - st) < 24) return a[23 - (i - st)];
    return 1'b0;
  endfunction

  task automatic doReset(input logic [2:0] m);
    rstN = 1'b0; mode = m; bitTick = 1'b0; bclkIn = 1'b0; lrclkIn = 1'b0;
    auxIn = 1'b0; errHold = 1'b0; unlock = 1'b0;
    capL = '0; capR = '0; frames = 0; curRight = 1'b1; idx = 0;
    falls = 0; fallsLast = 0; prevB = 1'b0; prevSd = 1'b0;
    lastLr = isI2sMode(m); curMode = m;
    repeat (3) @(negedge clk);
    // R12: outputs quiet in reset
    check("R12 reset outputs", {60'd0, bclkOut, lrclkOut, sdOut, auxValid}, 64'd0);
    check("R12 reset aux", {16'd0, auxLeft, auxRight}, 64'd0);
    rstN = 1'b1;
  endtask

  task automatic observe();
    logic isFall = prevB && !bclkOut;
    if (sdOut !== prevSd && !isFall) sdViol++;
    if (isFall) begin
      if (lrclkOut != lastLr) begin
        idx = 0;
        curRight = (lrclkOut != !isI2sMode(curMode));
        if (!curRight) begin
          frames++;
          fallsLast = falls;
          falls = 0;
        end
      end else begin
        idx++;
      end
      falls++;
      lastLr = lrclkOut;
      if (idx < 64) begin
        if (curRight) capR[63 - idx] = sdOut;
        else          capL[63 - idx] = sdOut;
      end
      auxIn = auxBitFor(curMode, curRight ? auxWR : auxWL, idx);
    end
    prevB = bclkOut;
    prevSd = sdOut;
  endtask

  task automatic runUntil(input int f, input logic side, input int ix);
    do begin
      @(negedge clk);
      observe();
    end while (!(frames == f && curRight == side && idx == ix));
  endtask

  task automatic slaveRun(input int nFrames, input int slot);
    logic ll = !isI2sMode(curMode);
    for (int f = 0; f < nFrames; f++)
      for (int ch = 0; ch < 2; ch++)
        for (int i = 0; i < slot; i++) begin
          @(negedge clk);
          lrclkIn = (ch == 0) ? ll : !ll;
          bclkIn = 1'b0;
          auxIn = auxBitFor(curMode, (ch == 0) ? auxWL : auxWR, i);
          repeat (4) @(negedge clk);
          bclkIn = 1'b1;
          repeat (4) @(negedge clk);
          if (ch == 0) capL[63 - i] = sdOut;
          else         capR[63 - i] = sdOut;
        end
    @(negedge clk);
    lrclkIn = ll;
    bclkIn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] a, b, c, d, e, g;
    sdViol = 0;
    // table walk: every format
    for (int v = 0; v < 8; v++) begin
      doReset(VECS[v].m);
      leftIn = VECS[v].l; rightIn = VECS[v].r;
      auxWL = VECS[v].al; auxWR = VECS[v].ar;
      if (VECS[v].m[2:1] != 2'b11) begin
        bitTick = 1'b1;
        runUntil(2, 1'b1, 31);
        // R2 R4 R5 R6 by mode, MSB first per R3
        check("R4 R5 R6 R2 left slot", capL, expVec(VECS[v].m, VECS[v].l, 32));
        check("R4 R5 R6 R2 right slot", capR, expVec(VECS[v].m, VECS[v].r, 32));
        runUntil(3, 1'b0, 0);
        check("R1 periods per frame", 64'(fallsLast), 64'd64);
        check("R10 aux strobe", {63'd0, auxValid}, 64'd1);
        check("R10 aux left", {40'd0, auxLeft}, {40'd0, VECS[v].al});
        check("R10 aux right", {40'd0, auxRight}, {40'd0, VECS[v].ar});
      end else begin
        slaveRun(3, int'(VECS[v].slot));
        check("R11 R5 R6 slave left", capL, expVec(VECS[v].m, VECS[v].l, int'(VECS[v].slot)));
        check("R11 R5 R6 slave right", capR, expVec(VECS[v].m, VECS[v].r, int'(VECS[v].slot)));
        check("R11 R10 slave aux left", {40'd0, auxLeft}, {40'd0, VECS[v].al});
        check("R11 R10 slave aux right", {40'd0, auxRight}, {40'd0, VECS[v].ar});
        check("R11 clock outputs low", {62'd0, bclkOut, lrclkOut}, 64'd0);
      end
    end

    // directed: latch point, error repeat, unlock
    a = 24'h123ABC; b = 24'hFEDC01; c = 24'h0A0B0C; d = 24'hF1E2D3;
    e = 24'h777001; g = 24'h888002;
    doReset(3'd4);
    auxWL = '0; auxWR = '0;
    leftIn = a; rightIn = b; bitTick = 1'b1;
    runUntil(2, 1'b0, 5);
    leftIn = c; rightIn = d;
    runUntil(2, 1'b1, 31);
    check("R7 right keeps frame pair", capR, expVec(3'd4, b, 32));
    runUntil(3, 1'b1, 31);
    check("R7 new pair left", capL, expVec(3'd4, c, 32));
    check("R7 new pair right", capR, expVec(3'd4, d, 32));
    runUntil(4, 1'b1, 10);
    errHold = 1'b1; leftIn = e; rightIn = g;
    runUntil(5, 1'b1, 31);
    check("R8 repeat left", capL, expVec(3'd4, c, 32));
    check("R8 repeat right", capR, expVec(3'd4, d, 32));
    errHold = 1'b0;
    runUntil(6, 1'b1, 31);
    check("R8 resume left", capL, expVec(3'd4, e, 32));
    errHold = 1'b1; unlock = 1'b1;
    runUntil(7, 1'b1, 31);
    check("R9 zero left", capL, 64'd0);
    check("R9 zero right", capR, 64'd0);
    errHold = 1'b0; unlock = 1'b0;
    runUntil(8, 1'b1, 31);
    check("R9 resume right", capR, expVec(3'd4, g, 32));
    check("R3 data moves only on falls", 64'(sdViol), 64'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule